// File: doc/BRIEF.md
# Halfword-Pair to Word Access Bridge

This bridge joins a 16-bit CPU-side slave port to a register target that only accepts whole 32-bit accesses. Two consecutive halfword cycles from the CPU are merged into a single 32-bit target cycle. A write half is held in a buffer until its partner arrives, and then one 32-bit write goes out with both halves in their lanes. A read half triggers one 32-bit target read. The requested half is returned and the other half is kept, so the partner read is served without touching the target again.

The two halves may come in either order. A pair is legal only when both halves fall inside the same 32-bit-aligned word, cover opposite halves of it, and share a direction. Byte-wide cycles and any cycle that lands in a prohibited address window are refused. Every refused cycle raises a one-clock interrupt pulse and sets a sticky flag that a separate clear input resets. It never reaches the target, and the pairing logic then starts over with the next cycle as a fresh first half.

Top module: `hw_pair_bridge`

## Requirements
- R1: After reset, req_ready_o is 1 and tgt_valid_o, rsp_valid_o, err_irq_o and err_sticky_o are 0.
- R2: A legal write pair, in either order, gives exactly one target write, issued only after the second half is accepted. Byte address bit 1 = 0 selects lane [15:0] and bit 1 = 1 selects lane [31:16]. tgt_addr_o is the word address with bits [1:0] = 0.
- R3: A first read half gives exactly one target read and returns the addressed half of tgt_rdata_i. The legal partner read returns the other half with no further target access.
- R4: A second half in a different 32-bit word, or naming the same half again, is an error and causes no target access. This includes adjacent halves such as 0x02 then 0x04.
- R5: A second half whose direction differs from the first is an error with no target access, even when the addresses pair correctly.
- R6: A cycle with req_byte_i = 1 is an error in either slot and causes no target access.
- R7: A cycle whose byte address lies in [PROHIB_LO, PROHIB_HI] is an error and causes no target access.
- R8: Each refused cycle raises err_irq_o for exactly one clock and sets err_sticky_o. err_sticky_o stays set until err_clr_i is seen, and an error in the same cycle takes precedence over the clear.
- R9: After an error the pairing returns to idle, so the next cycle is taken as a first half.
- R10: Every accepted cycle gets one rsp_valid_o pulse. It comes one clock after acceptance, or one clock after the target handshake when the cycle needs the target. rsp_rdata_o is 0 for writes and errors. req_ready_o is 0 while a target access is pending, and the target request holds steady until tgt_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | CPU cycle present |
| req_ready_o | output | 1 | Bridge can accept a CPU cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_byte_i | input | 1 | Cycle is byte-wide |
| req_hw_addr_i | input | ADDR_W-1 | Halfword address (byte address bits [ADDR_W-1:1]) |
| req_wdata_i | input | 16 | Write halfword |
| rsp_valid_o | output | 1 | Response pulse for an accepted cycle |
| rsp_rdata_o | output | 16 | Read halfword |
| tgt_valid_o | output | 1 | Target access request |
| tgt_ready_i | input | 1 | Target accepts the access |
| tgt_write_o | output | 1 | Target access is a write |
| tgt_addr_o | output | ADDR_W | Word-aligned target byte address |
| tgt_wdata_o | output | 32 | Target write word |
| tgt_rdata_i | input | 32 | Target read word, valid with tgt_ready_i |
| err_irq_o | output | 1 | One-clock error interrupt |
| err_sticky_o | output | 1 | Sticky error flag |
| err_clr_i | input | 1 | Clears the sticky flag |

## Verification
A corrupted pairing state shows up at the ports by the second half of the next pair at the latest. A lost first half turns a legal partner into an extra target read or a spurious error pulse. A stale half gives a wrong lane in the target write word, or a wrong read halfword one clock after the partner is accepted. A missed return to idle after an error makes the following legal cycle fail pairing, which shows as an error pulse one clock after that cycle is accepted.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_RD,
    ST_WR
  } hpb_state_e;
endpackage

// File: rtl/hpb_classify.sv
module hpb_classify #(
  parameter int ADDR_W    = 8,
  parameter int PROHIB_LO = 'hF0,
  parameter int PROHIB_HI = 'hFF
) (
  input  logic [ADDR_W-2:0] hw_addr_i,
  input  logic              write_i,
  input  logic              byte_i,
  input  logic              pend_i,
  input  logic [ADDR_W-3:0] pend_word_i,
  input  logic              pend_lane_i,
  input  logic              pend_write_i,
  output logic              err_o
);
  logic [ADDR_W-1:0] byte_addr;
  logic              prohib;
  logic              pair_bad;

  assign byte_addr = {hw_addr_i, 1'b0};
  assign prohib    = (byte_addr >= ADDR_W'(PROHIB_LO)) && (byte_addr <= ADDR_W'(PROHIB_HI));
  // legal partner: same word, opposite half, same direction
  assign pair_bad  = pend_i && ((write_i != pend_write_i) ||
                                (hw_addr_i[ADDR_W-2:1] != pend_word_i) ||
                                (hw_addr_i[0] == pend_lane_i));
  assign err_o     = byte_i || prohib || pair_bad;
endmodule

// File: rtl/hpb_lanes.sv
module hpb_lanes
  import hpb_pkg::*;
(
  input  logic              first_lane_i,
  input  logic [HALF_W-1:0] first_i,
  input  logic [HALF_W-1:0] second_i,
  output logic [WORD_W-1:0] word_o,
  input  logic [WORD_W-1:0] rword_i,
  input  logic              rd_lane_i,
  output logic [HALF_W-1:0] rd_sel_o,
  output logic [HALF_W-1:0] rd_other_o
);
  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign word_o[i*HALF_W +: HALF_W] = (first_lane_i == 1'(i)) ? first_i : second_i;
  end

  assign rd_sel_o   = rd_lane_i ? rword_i[WORD_W-1:HALF_W] : rword_i[HALF_W-1:0];
  assign rd_other_o = rd_lane_i ? rword_i[HALF_W-1:0]      : rword_i[WORD_W-1:HALF_W];
endmodule

// File: rtl/hw_pair_bridge.sv
module hw_pair_bridge
  import hpb_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PROHIB_LO = 'hF0,
  parameter int PROHIB_HI = 'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_byte_i,
  input  logic [ADDR_W-2:0] req_hw_addr_i,
  input  logic [15:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_rdata_o,
  output logic              tgt_valid_o,
  input  logic              tgt_ready_i,
  output logic              tgt_write_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [31:0]       tgt_wdata_o,
  input  logic [31:0]       tgt_rdata_i,
  output logic              err_irq_o,
  output logic              err_sticky_o,
  input  logic              err_clr_i
);
  localparam int WORD_AW = ADDR_W - 2;

  hpb_state_e          state_q;
  logic [WORD_AW-1:0]  word_q;
  logic                lane_q;
  logic                dir_q;
  logic [HALF_W-1:0]   hbuf_q;   // first write half, or unread half of a read
  logic [HALF_W-1:0]   sec_q;
  logic                rsp_valid_q;
  logic [HALF_W-1:0]   rsp_data_q;
  logic                irq_q;
  logic                sticky_q;

  logic                acc;
  logic                cls_err;
  logic                err_now;
  logic [HALF_W-1:0]   rd_sel;
  logic [HALF_W-1:0]   rd_other;

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_PEND);
  assign acc         = req_valid_i && req_ready_o;
  assign err_now     = acc && cls_err;

  hpb_classify #(
    .ADDR_W   (ADDR_W),
    .PROHIB_LO(PROHIB_LO),
    .PROHIB_HI(PROHIB_HI)
  ) u_classify (
    .hw_addr_i   (req_hw_addr_i),
    .write_i     (req_write_i),
    .byte_i      (req_byte_i),
    .pend_i      (state_q == ST_PEND),
    .pend_word_i (word_q),
    .pend_lane_i (lane_q),
    .pend_write_i(dir_q),
    .err_o       (cls_err)
  );

  hpb_lanes u_lanes (
    .first_lane_i(lane_q),
    .first_i     (hbuf_q),
    .second_i    (sec_q),
    .word_o      (tgt_wdata_o),
    .rword_i     (tgt_rdata_i),
    .rd_lane_i   (lane_q),
    .rd_sel_o    (rd_sel),
    .rd_other_o  (rd_other)
  );

  assign tgt_valid_o  = (state_q == ST_RD) || (state_q == ST_WR);
  assign tgt_write_o  = (state_q == ST_WR);
  assign tgt_addr_o   = {word_q, 2'b00};
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rsp_data_q;
  assign err_irq_o    = irq_q;
  assign err_sticky_o = sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      word_q      <= '0;
      lane_q      <= 1'b0;
      dir_q       <= 1'b0;
      hbuf_q      <= '0;
      sec_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      irq_q       <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      irq_q       <= 1'b0;
      case (state_q)
        ST_IDLE: if (acc) begin
          if (cls_err) begin
            irq_q       <= 1'b1;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= '0;
          end else begin
            word_q <= req_hw_addr_i[ADDR_W-2:1];
            lane_q <= req_hw_addr_i[0];
            dir_q  <= req_write_i;
            if (req_write_i) begin
              hbuf_q      <= req_wdata_i;
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= '0;
              state_q     <= ST_PEND;
            end else begin
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: if (tgt_ready_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= rd_sel;
          hbuf_q      <= rd_other;
          state_q     <= ST_PEND;
        end
        ST_PEND: if (acc) begin
          if (cls_err) begin
            irq_q       <= 1'b1;
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= '0;
            state_q     <= ST_IDLE;
          end else if (dir_q) begin
            sec_q   <= req_wdata_i;
            state_q <= ST_WR;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= hbuf_q;
            state_q     <= ST_IDLE;
          end
        end
        ST_WR: if (tgt_ready_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= '0;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sticky_q <= 1'b0;
    else if (err_now)   sticky_q <= 1'b1;
    else if (err_clr_i) sticky_q <= 1'b0;
  end
endmodule

// File: rtl/hpb_checker.sv
module hpb_checker #(
  parameter int ADDR_W    = 8,
  parameter int PROHIB_LO = 'hF0,
  parameter int PROHIB_HI = 'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              tgt_valid_o,
  input logic              tgt_ready_i,
  input logic              tgt_write_o,
  input logic [ADDR_W-1:0] tgt_addr_o,
  input logic              err_irq_o,
  input logic              err_sticky_o,
  input logic              err_clr_i
);
  // R2
  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> (tgt_addr_o[1:0] == 2'b00));

  // R10
  a_r10_no_accept_in_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> !req_ready_o);

  a_r10_target_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && !tgt_ready_i) |=> (tgt_valid_o && $stable(tgt_addr_o) && $stable(tgt_write_o)));

  // R4
  a_r4_no_target_after_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> !tgt_valid_o);

  // R7
  a_r7_target_outside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_valid_o |-> ((tgt_addr_o + ADDR_W'(3) < ADDR_W'(PROHIB_LO)) || (tgt_addr_o > ADDR_W'(PROHIB_HI))));

  // R8
  a_r8_sticky_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> err_sticky_o);

  a_r8_clear_only_by_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_sticky_o) |-> $past(err_clr_i));
endmodule

bind hw_pair_bridge hpb_checker #(
  .ADDR_W   (ADDR_W),
  .PROHIB_LO(PROHIB_LO),
  .PROHIB_HI(PROHIB_HI)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .tgt_valid_o (tgt_valid_o),
  .tgt_ready_i (tgt_ready_i),
  .tgt_write_o (tgt_write_o),
  .tgt_addr_o  (tgt_addr_o),
  .err_irq_o   (err_irq_o),
  .err_sticky_o(err_sticky_o),
  .err_clr_i   (err_clr_i)
);

// File: tb/hw_pair_bridge_tb.sv
module hw_pair_bridge_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_byte = 1'b0;
  logic [AW-2:0] req_hw_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [15:0]   rsp_rdata;
  logic          tgt_valid;
  logic          tgt_rdy = 1'b1;
  logic          tgt_write;
  logic [AW-1:0] tgt_addr;
  logic [31:0]   tgt_wdata;
  logic [31:0]   tgt_rdata;
  logic          err_irq;
  logic          err_sticky;
  logic          err_clr = 1'b0;

  int checks = 0, errors = 0;
  int tgt_cnt = 0, irq_cnt = 0;
  logic [AW-1:0] last_wa = '0;
  logic [31:0]   last_wd = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // target model: word content derived from its address
  assign tgt_rdata = {tgt_addr, 8'h5A, ~tgt_addr, 8'hC3};

  hw_pair_bridge #(.ADDR_W(AW), .PROHIB_LO('hF0), .PROHIB_HI('hFF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_byte_i(req_byte), .req_hw_addr_i(req_hw_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .tgt_valid_o(tgt_valid), .tgt_ready_i(tgt_rdy), .tgt_write_o(tgt_write),
    .tgt_addr_o(tgt_addr), .tgt_wdata_o(tgt_wdata), .tgt_rdata_i(tgt_rdata),
    .err_irq_o(err_irq), .err_sticky_o(err_sticky), .err_clr_i(err_clr)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (tgt_valid && tgt_rdy) begin
        tgt_cnt++;
        if (tgt_write) begin
          last_wa = tgt_addr;
          last_wd = tgt_wdata;
        end
      end
      if (err_irq) irq_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic by, input logic [7:0] a,
                     input logic [15:0] d, output logic [15:0] rd,
                     output int derr, output int dtgt);
    int e0 = irq_cnt;
    int t0 = tgt_cnt;
    int n = 0;
    @(negedge clk);
    while (!req_ready && n < 20) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_write = wr; req_byte = by;
    req_hw_addr = a[7:1]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    rd = rsp_rdata;
    @(negedge clk);
    derr = irq_cnt - e0;
    dtgt = tgt_cnt - t0;
  endtask

  typedef struct packed {
    logic        wr;
    logic        by;
    logic [7:0]  a;
    logic [15:0] d;
    logic        eerr;
    logic [1:0]  etgt;
    logic [15:0] erd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h10, 16'h0000, 1'b0, 2'd1, 16'hEFC3}, // R3 first read low
    '{1'b0, 1'b0, 8'h12, 16'h0000, 1'b0, 2'd0, 16'h105A}, // R3 partner from latch
    '{1'b0, 1'b0, 8'h22, 16'h0000, 1'b0, 2'd1, 16'h205A}, // R3 high first
    '{1'b0, 1'b0, 8'h20, 16'h0000, 1'b0, 2'd0, 16'hDFC3}, // R3 low second
    '{1'b1, 1'b0, 8'h30, 16'h1111, 1'b0, 2'd0, 16'h0000}, // R2 no early write
    '{1'b1, 1'b0, 8'h32, 16'h2222, 1'b0, 2'd1, 16'h0000}, // R2 one write
    '{1'b0, 1'b0, 8'h02, 16'h0000, 1'b0, 2'd1, 16'h005A}, // R3
    '{1'b0, 1'b0, 8'h04, 16'h0000, 1'b1, 2'd0, 16'h0000}, // R4 straddle
    '{1'b1, 1'b0, 8'h40, 16'h3333, 1'b0, 2'd0, 16'h0000}, // R2
    '{1'b0, 1'b0, 8'h42, 16'h0000, 1'b1, 2'd0, 16'h0000}, // R5 write then read
    '{1'b0, 1'b0, 8'h40, 16'h0000, 1'b0, 2'd1, 16'hBFC3}, // R9 fresh first half
    '{1'b1, 1'b0, 8'h42, 16'h4444, 1'b1, 2'd0, 16'h0000}, // R5 read then write
    '{1'b1, 1'b1, 8'h50, 16'h0055, 1'b1, 2'd0, 16'h0000}, // R6 byte write
    '{1'b1, 1'b0, 8'hF4, 16'h6666, 1'b1, 2'd0, 16'h0000}, // R7 window write
    '{1'b0, 1'b0, 8'hF8, 16'h0000, 1'b1, 2'd0, 16'h0000}, // R7 window read
    '{1'b1, 1'b0, 8'h60, 16'h7777, 1'b0, 2'd0, 16'h0000}, // R2
    '{1'b1, 1'b0, 8'h60, 16'h8888, 1'b1, 2'd0, 16'h0000}  // R4 same half twice
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    int derr, dtgt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 tgt_valid", 32'(tgt_valid), 32'd0);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 irq", 32'(err_irq), 32'd0);
    chk("R1 sticky", 32'(err_sticky), 32'd0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].wr, VEC[i].by, VEC[i].a, VEC[i].d, rd, derr, dtgt);
      chk($sformatf("R8 irq pulses vec %0d", i), 32'(derr), 32'(VEC[i].eerr));
      chk($sformatf("R2/R3 target count vec %0d", i), 32'(dtgt), 32'(VEC[i].etgt));
      chk($sformatf("R10 rdata vec %0d", i), 32'(rd), 32'(VEC[i].erd));
    end

    // R2 lane placement, low then high pair
    chk("R2 write addr", 32'(last_wa), 32'h30);
    chk("R2 write data", last_wd, 32'h2222_1111);
    // R8 sticky held, then cleared
    chk("R8 sticky set", 32'(err_sticky), 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R8 sticky cleared", 32'(err_sticky), 32'd0);

    // R2 high then low
    cyc(1'b1, 1'b0, 8'h76, 16'hAAAA, rd, derr, dtgt);
    chk("R2 no write on first half", 32'(dtgt), 32'd0);
    cyc(1'b1, 1'b0, 8'h74, 16'hBBBB, rd, derr, dtgt);
    chk("R2 reverse pair count", 32'(dtgt), 32'd1);
    chk("R2 reverse addr", 32'(last_wa), 32'h74);
    chk("R2 reverse data", last_wd, 32'hAAAA_BBBB);
    chk("R8 no error on legal pair", 32'(err_sticky), 32'd0);

    // R10 stalled target read
    tgt_rdy = 1'b0;
    fork
      cyc(1'b0, 1'b0, 8'h80, 16'h0000, rd, derr, dtgt);
      begin repeat (4) @(negedge clk); tgt_rdy = 1'b1; end
    join
    chk("R10 stalled read data", 32'(rd), 32'h7FC3);
    chk("R10 stalled read count", 32'(dtgt), 32'd1);
    cyc(1'b0, 1'b0, 8'h82, 16'h0000, rd, derr, dtgt);
    chk("R3 partner after stall", 32'(rd), 32'h805A);
    chk("R3 partner no access", 32'(dtgt), 32'd0);

    // R6 byte cycle as second half, R9 restart
    cyc(1'b1, 1'b0, 8'h90, 16'h1234, rd, derr, dtgt);
    cyc(1'b1, 1'b1, 8'h92, 16'h0056, rd, derr, dtgt);
    chk("R6 byte second half error", 32'(derr), 32'd1);
    chk("R6 byte second half no write", 32'(dtgt), 32'd0);
    cyc(1'b1, 1'b0, 8'h92, 16'h5678, rd, derr, dtgt);
    chk("R9 new first half no write", 32'(dtgt), 32'd0);
    cyc(1'b1, 1'b0, 8'h90, 16'h9ABC, rd, derr, dtgt);
    chk("R9 pair after restart", last_wd, 32'h5678_9ABC);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule